// File: doc/BRIEF.md
# Split-Access 64-bit Time Base Counter

A free-running 64-bit unsigned counter that a 32-bit processor reaches through a special-purpose-register style port, one 32-bit half per access. Each cycle in which the external `tick_en` strobe is high advances the count by one. The strobe sets the update rate, so the block fixes no frequency. The lower half carries into the upper half within the same cycle.

Reads and writes use separate register numbers. Read numbers 268 (lower half) and 269 (upper half) work at any privilege level. Write numbers 284 (lower half) and 285 (upper half) take effect only while `sup_mode` is high. A user-level write changes nothing and raises a one-cycle privilege error. No access returns all 64 bits at once, so software reads the halves one after the other. Read results are registered and appear one cycle after the request. Reset clears only the response outputs; the count itself is not cleared.

Top module: `tbase_split_counter`

## Requirements
- R1: When no write hits a half, the 64-bit count rises by exactly one in each cycle where `tick_en` is 1 and holds in each cycle where `tick_en` is 0.
- R2: A read request (`req_write`=0) to number 268 puts the low 32 bits on `rd_data` with `rd_hit`=1 in the next cycle. The value is the count as it stood in the request cycle, before that cycle's tick.
- R3: A read request to number 269 puts the high 32 bits on `rd_data` with `rd_hit`=1 in the next cycle, with the same timing as R2.
- R4: Reads of 268 and 269 succeed whether `sup_mode` is 0 or 1.
- R5: When a tick finds the low half at 0xFFFFFFFF, the low half becomes 0 and the high half rises by one in the same cycle. An all-ones 64-bit count wraps to zero.
- R6: A write (`req_write`=1, `sup_mode`=1) to 284 replaces only the low half, and a write to 285 replaces only the high half. A written half takes `req_wdata` even when a tick arrives in the same cycle, and the other half still receives any carry from that tick.
- R7: A write to 284 or 285 with `sup_mode`=0 leaves the count unchanged. In the next cycle it gives `priv_err`=1 for one cycle, `rd_hit`=0 and `rd_data`=0.
- R8: An access to any other number, including a read of 284/285 or a write to 268/269, gives `rd_data`=0, `rd_hit`=0 and `priv_err`=0 in the next cycle, and leaves the count unchanged.
- R9: Synchronous reset (`rst`=1) forces `rd_data`, `rd_hit` and `priv_err` to 0 but neither clears nor stops the count.
- R10: An accepted supervisor write gives `rd_hit`=1 and `rd_data`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the response outputs |
| tick_en | input | 1 | Periodic increment strobe |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_spr | input | 10 | Register number of the access |
| req_wdata | input | 32 | Write data for one half |
| sup_mode | input | 1 | Supervisor privilege flag |
| rd_data | output | 32 | Registered read data, zero unless a read hit |
| rd_hit | output | 1 | Registered: the previous request was a recognised, permitted access |
| priv_err | output | 1 | Registered: the previous request was a user-level write |

## Verification
The embedded assertions check on every cycle how each half steps, holds or takes a written value, and that the previous cycle's count appears on a read hit. They also check that a denied write raises the error flag without a hit, and that data stays zero whenever there is no hit. Other behaviour only the bench's scenarios can show, by comparing the ports on every cycle with a 64-bit behavioural model. These cases are the carry across the 32-bit boundary, the full 64-bit wrap, a write that lands on a tick that carries, a count that survives reset, and the rejection of swapped read and write numbers.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    localparam int unsigned TBC_HALF_W  = 32;
    localparam int unsigned TBC_SPR_W   = 10;
    localparam int unsigned TBC_RD_LO   = 268;
    localparam int unsigned TBC_RD_HI   = 269;
    localparam int unsigned TBC_WR_LO   = 284;
    localparam int unsigned TBC_WR_HI   = 285;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_READ   = 2'd1,
        ACC_WRITE  = 2'd2,
        ACC_DENIED = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      upper;
    } acc_dec_t;

    function automatic logic hits_half(input acc_dec_t d, input logic want_upper);
        return (d.kind == ACC_WRITE) && (d.upper == want_upper);
    endfunction

endpackage

// File: rtl/tbc_spr_decode.sv
module tbc_spr_decode
    import tbc_pkg::*;
#(
    parameter int unsigned SPR_W = TBC_SPR_W,
    parameter int unsigned RD_LO = TBC_RD_LO,
    parameter int unsigned RD_HI = TBC_RD_HI,
    parameter int unsigned WR_LO = TBC_WR_LO,
    parameter int unsigned WR_HI = TBC_WR_HI
) (
    input  logic             valid,
    input  logic             write,
    input  logic [SPR_W-1:0] spr,
    input  logic             sup,
    output acc_dec_t         dec
);
    logic is_rd_lo, is_rd_hi, is_wr_lo, is_wr_hi;

    always_comb begin
        is_rd_lo = (spr == SPR_W'(RD_LO));
        is_rd_hi = (spr == SPR_W'(RD_HI));
        is_wr_lo = (spr == SPR_W'(WR_LO));
        is_wr_hi = (spr == SPR_W'(WR_HI));
        dec.kind  = ACC_NONE;
        dec.upper = 1'b0;
        if (valid) begin
            if (!write && (is_rd_lo || is_rd_hi)) begin
                dec.kind  = ACC_READ;
                dec.upper = is_rd_hi;
            end else if (write && (is_wr_lo || is_wr_hi)) begin
                dec.kind  = sup ? ACC_WRITE : ACC_DENIED;
                dec.upper = is_wr_hi;
            end
        end
    end
endmodule

// File: rtl/tbc_half.sv
module tbc_half #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_in,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt
);
    // Count register is deliberately outside reset.
    always_ff @(posedge clk) begin
        if (wr_en)
            cnt <= wdata;
        else if (inc_in)
            cnt <= cnt + W'(1);
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc_in && !wr_en) |=> $stable(cnt)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc_in && !wr_en) |=> (cnt == W'($past(cnt) + W'(1)))); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == $past(wdata))); // R6
endmodule

// File: rtl/tbc_read_port.sv
module tbc_read_port
    import tbc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_dec_t     dec,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] rd_data,
    output logic         rd_hit,
    output logic         priv_err
);
    logic [W-1:0] sel_data;

    always_comb begin
        sel_data = '0;
        if (dec.kind == ACC_READ)
            sel_data = dec.upper ? hi : lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_hit   <= 1'b0;
            priv_err <= 1'b0;
        end else begin
            rd_data  <= sel_data;
            rd_hit   <= (dec.kind == ACC_READ) || (dec.kind == ACC_WRITE);
            priv_err <= (dec.kind == ACC_DENIED);
        end
    end

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (rd_data == '0)); // R8
    AST_ERR_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        priv_err |-> !rd_hit); // R7
    AST_READ_UPPER: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == ACC_READ && dec.upper) |=> (rd_hit && rd_data == $past(hi))); // R3
endmodule

// File: rtl/tbase_split_counter.sv
module tbase_split_counter
    import tbc_pkg::*;
#(
    parameter int unsigned HALF_W = TBC_HALF_W,
    parameter int unsigned SPR_W  = TBC_SPR_W,
    parameter int unsigned RD_LO  = TBC_RD_LO,
    parameter int unsigned RD_HI  = TBC_RD_HI,
    parameter int unsigned WR_LO  = TBC_WR_LO,
    parameter int unsigned WR_HI  = TBC_WR_HI
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SPR_W-1:0]  req_spr,
    input  logic [HALF_W-1:0] req_wdata,
    input  logic              sup_mode,
    output logic [HALF_W-1:0] rd_data,
    output logic              rd_hit,
    output logic              priv_err
);
    localparam int unsigned NUM_HALVES = 2;

    acc_dec_t          dec;
    logic [HALF_W-1:0] half_val [NUM_HALVES];
    logic              inc_chain [NUM_HALVES];

    tbc_spr_decode #(
        .SPR_W(SPR_W), .RD_LO(RD_LO), .RD_HI(RD_HI), .WR_LO(WR_LO), .WR_HI(WR_HI)
    ) u_dec (
        .valid(req_valid), .write(req_write), .spr(req_spr), .sup(sup_mode), .dec(dec)
    );

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        if (g == 0) begin : g_base
            assign inc_chain[g] = tick_en;
        end else begin : g_carry
            // ripple carry: previous half all ones and being ticked
            assign inc_chain[g] = inc_chain[g-1] & (&half_val[g-1]);
        end
        tbc_half #(.W(HALF_W)) u_half (
            .clk(clk), .rst(rst),
            .inc_in(inc_chain[g]),
            .wr_en(hits_half(dec, g == 1)),
            .wdata(req_wdata),
            .cnt(half_val[g])
        );
    end

    tbc_read_port #(.W(HALF_W)) u_rd (
        .clk(clk), .rst(rst), .dec(dec),
        .lo(half_val[0]), .hi(half_val[1]),
        .rd_data(rd_data), .rd_hit(rd_hit), .priv_err(priv_err)
    );

    AST_DENIED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !sup_mode &&
         (req_spr == SPR_W'(WR_LO) || req_spr == SPR_W'(WR_HI))) |=> (priv_err && !rd_hit)); // R7
    AST_READ_LOWER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_spr == SPR_W'(RD_LO))
        |=> (rd_hit && rd_data == $past(half_val[0]))); // R2
    AST_CARRY_UP: assert property (@(posedge clk) disable iff (rst)
        (tick_en && (&half_val[0]) && dec.kind != ACC_WRITE)
        |=> (half_val[1] == HALF_W'($past(half_val[1]) + HALF_W'(1)) && half_val[0] == '0)); // R5
endmodule

// File: tb/tb_tbase_split_counter.sv
module tb_tbase_split_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_spr = '0;
    logic [31:0] req_wdata = '0;
    logic        sup_mode = 1'b0;
    logic [31:0] rd_data;
    logic        rd_hit;
    logic        priv_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    longint unsigned ref_cnt = 0;

    always #5 clk = ~clk;

    tbase_split_counter dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .req_valid(req_valid),
        .req_write(req_write), .req_spr(req_spr), .req_wdata(req_wdata),
        .sup_mode(sup_mode), .rd_data(rd_data), .rd_hit(rd_hit), .priv_err(priv_err)
    );

    // One cycle: drive at negedge, predict, advance model, compare at next negedge.
    task automatic cyc(input string tag, input bit v, input bit w, input int spr,
                       input logic [31:0] wd, input bit sup, input bit tk);
        logic [31:0] lo, hi, nlo, nhi, e_data;
        bit e_hit, e_err, carry;
        req_valid = v; req_write = w; req_spr = 10'(spr);
        req_wdata = wd; sup_mode = sup; tick_en = tk;
        lo = ref_cnt[31:0];
        hi = ref_cnt[63:32];
        e_hit = 0; e_err = 0; e_data = '0;
        if (!rst && v) begin
            if (!w && spr == 268) begin e_hit = 1; e_data = lo; end
            if (!w && spr == 269) begin e_hit = 1; e_data = hi; end
            if (w && (spr == 284 || spr == 285)) begin
                if (sup) e_hit = 1; else e_err = 1;
            end
        end
        carry = tk && (lo == 32'hFFFF_FFFF);
        nlo = tk ? lo + 32'd1 : lo;
        nhi = hi + {31'd0, carry};
        if (v && w && sup && spr == 284) nlo = wd;
        if (v && w && sup && spr == 285) nhi = wd;
        ref_cnt = {nhi, nlo};
        @(negedge clk);
        checks++;
        if (rd_data !== e_data || rd_hit !== e_hit || priv_err !== e_err) begin
            errors++;
            $display("FAIL %s: data=%h hit=%b err=%b expected data=%h hit=%b err=%b",
                     tag, rd_data, rd_hit, priv_err, e_data, e_hit, e_err);
        end
    endtask

    task automatic idle(input string tag, input bit tk);
        cyc(tag, 0, 0, 0, '0, 0, tk);
    endtask
    task automatic rd(input string tag, input int spr, input bit sup);
        cyc(tag, 1, 0, spr, '0, sup, 0);
    endtask
    task automatic wr(input string tag, input int spr, input logic [31:0] d, input bit sup);
        cyc(tag, 1, 1, spr, d, sup, 0);
    endtask

    initial begin
        @(negedge clk);
        // R9: writes taken while reset holds the outputs at zero
        wr("R9 write lo in reset", 284, 32'd5, 1);
        wr("R9 write hi in reset", 285, 32'd7, 1);
        rd("R9 read masked in reset", 268, 1);
        rst = 1'b0;
        rd("R2 read lo", 268, 0);
        rd("R3 read hi", 269, 0);
        rd("R4 user read hi", 269, 0);
        rd("R4 sup read lo", 268, 1);
        // R1: ticks advance, idle holds
        for (int i = 0; i < 10; i++) idle("R1 tick", 1);
        for (int i = 0; i < 3; i++) idle("R1 hold", 0);
        rd("R1 read lo after ticks", 268, 0);
        cyc("R2 read lo with tick returns pre-tick value", 1, 0, 268, '0, 0, 1);
        rd("R2 read lo after tick", 268, 0);
        // R5: carry across halves
        wr("R10 sup write lo ack", 284, 32'hFFFF_FFFE, 1);
        wr("R10 sup write hi ack", 285, 32'd0, 1);
        for (int i = 0; i < 3; i++) idle("R5 tick over boundary", 1);
        rd("R5 hi after carry", 269, 0);
        rd("R5 lo after carry", 268, 0);
        wr("R5 set lo ones", 284, 32'hFFFF_FFFF, 1);
        wr("R5 set hi ones", 285, 32'hFFFF_FFFF, 1);
        idle("R5 full wrap tick", 1);
        rd("R5 lo wrapped", 268, 0);
        rd("R5 hi wrapped", 269, 0);
        // R6: write vs tick collision
        wr("R6 set lo ones", 284, 32'hFFFF_FFFF, 1);
        wr("R6 set hi", 285, 32'd3, 1);
        cyc("R6 write lo with carrying tick", 1, 1, 284, 32'h0000_1234, 1, 1);
        rd("R6 lo written value wins", 268, 0);
        rd("R6 hi got carry", 269, 0);
        cyc("R6 write hi with tick", 1, 1, 285, 32'hABCD_0000, 1, 1);
        rd("R6 lo still ticked", 268, 0);
        rd("R6 hi written", 269, 0);
        // R7: user writes rejected
        wr("R7 user write lo", 284, 32'hDEAD_BEEF, 0);
        wr("R7 user write hi", 285, 32'hDEAD_BEEF, 0);
        idle("R7 err pulse ends", 0);
        rd("R7 lo unchanged", 268, 0);
        rd("R7 hi unchanged", 269, 0);
        // R8: unknown or swapped numbers
        rd("R8 read unknown", 300, 1);
        rd("R8 read write-number", 284, 1);
        wr("R8 write read-number", 268, 32'h1111_1111, 1);
        wr("R8 write unknown", 9, 32'h2222_2222, 0);
        rd("R8 lo unchanged", 268, 0);
        rd("R8 hi unchanged", 269, 0);
        // R9: reset keeps the count, ticks still counted
        rst = 1'b1;
        idle("R9 reset hold", 0);
        idle("R9 reset tick", 1);
        rd("R9 read masked", 269, 0);
        rst = 1'b0;
        rd("R9 lo survives reset", 268, 0);
        rd("R9 hi survives reset", 269, 0);
        // Mixed traffic near the boundary
        wr("R5 near boundary", 284, 32'hFFFF_FF80, 1);
        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom;
            int sp;
            case (r[2:0])
                3'd0, 3'd1: sp = 268;
                3'd2, 3'd3: sp = 269;
                3'd4: sp = 284;
                3'd5: sp = 285;
                default: sp = 270;
            endcase
            cyc("R1 mixed traffic", r[3], r[4] & r[5], sp, $urandom, r[6], r[7] | r[8]);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule